// File: doc/BRIEF.md
# NAND Page Transfer DMA Sequencer

The block paces one page transfer between a single-level-cell NAND device and a system DMA engine. Software sets the transfer direction, the bus width, burst use, ECC folding and forced chip select in a configuration word. It loads a byte count and then starts the transfer with a control write. The same control write can also clear the running ECC accumulator.

A 32-bit data word passes between the DMA engine and the flash stream on each request/acknowledge handshake. The count goes down by four bytes per word. If fewer than four bytes remain, it goes down by the remainder. At zero the transfer stops and a sticky terminal-count flag is raised. A second sticky flag records each rising edge of the flash ready line. Each flag can drive the interrupt output through its own enable bit, and each is cleared by writing a one to its bit in a separate clear register. Typical counts are 0x840 for a 2048+64 byte page, 0x210 for a 512+16 byte page, and 0x10 or 0x04 for a spare-area-only transfer.

Requests go out singly, or in groups of four words when bursts are enabled and at least 16 bytes remain. A new request waits while the flash ready line is low. The ECC logic here is a stand-in: an XOR fold of the words moved, because the real code algorithm lies outside this block.

Top module: `nand_dma_seq`

## Requirements
- R1: After reset, every readable register reads 0, dma_req and irq are low and fl_ce_n is high.
- R2: Config (address 0) stores bits [5:0] and reads them back. Bit 0 drives fl_wide, bit 1 drives fl_dir_rd (1 = flash to memory), bit 5 forces fl_ce_n low, and fl_ce_n is also low whenever a transfer is active.
- R3: A write to the count register (address 5) loads bits [11:0] while idle and is ignored while a transfer is active. Reads of address 5 return the bytes still remaining.
- R4: A control write (address 1) with bit 0 set starts a transfer only when the block is idle and the count is non-zero. In any other case it has no effect.
- R5: Each accepted word (dma_req and dma_ack high in the same cycle) lowers the count by 4, or by the remaining count when that is below 4.
- R6: When the count reaches zero the transfer ends: dma_req is low from the next cycle and status bit 1 (address 3) is set.
- R7: Writing the clear register (address 4) with bit 1 clears status bit 1, and with bit 0 clears status bit 0. A flag being set in the same cycle as its clear stays set.
- R8: Status bit 0 is set on each rising edge of fl_ready.
- R9: irq is high when any status bit is set and its enable bit (address 2, same bit positions) is set.
- R10: With config bit 2 set and at least 16 bytes remaining at a request boundary, dma_burst is high and the request stays up for 4 accepted words, whatever fl_ready does. In every other case each request covers one word.
- R11: At a request boundary, dma_req stays low while fl_ready is low.
- R12: With config bit 3 set, each accepted word is XOR-folded into the ECC accumulator (address 6). A control write with bit 1 set clears the accumulator. With bit 3 clear the accumulator does not change.
- R13: In read direction dma_rdata follows fl_rdata and fl_rstb pulses for each accepted word. In write direction fl_wdata follows dma_wdata and fl_wstb pulses for each accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | Word transfer request to the DMA engine |
| dma_burst | output | 1 | Current request is a 4-word burst |
| dma_ack | input | 1 | DMA engine moves one word this cycle |
| dma_wdata | input | 32 | Word from memory (write direction) |
| dma_rdata | output | 32 | Word to memory (read direction) |
| fl_ready | input | 1 | Flash ready |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_wide | output | 1 | 16-bit flash bus selected |
| fl_dir_rd | output | 1 | Direction: 1 = flash to memory |
| fl_wdata | output | 32 | Word toward flash |
| fl_wstb | output | 1 | Word toward flash is valid |
| fl_rdata | input | 32 | Word from flash |
| fl_rstb | output | 1 | Word from flash consumed |

## Verification
The hardest cases to reach are a clear that lands in the very cycle its flag is set, and fl_ready falling in the middle of a burst. The bench arranges the first by holding the DMA acknowledge low on a 4-byte transfer and then releasing it for a single cycle, in the same cycle as the clear write. It reaches the second by toggling fl_ready pseudo-randomly during a full 0x840-byte burst transfer. A behavioural model compares every output against the design on every cycle. An 18-byte transfer covers both the burst-to-single switch and the short final word.

// File: rtl/nds_pkg.sv
package nds_pkg;
  typedef enum logic [2:0] {
    RA_CFG  = 3'd0,
    RA_CTRL = 3'd1,
    RA_IEN  = 3'd2,
    RA_STAT = 3'd3,
    RA_ICLR = 3'd4,
    RA_TCNT = 3'd5,
    RA_ECC  = 3'd6
  } reg_addr_e;

  localparam int CFG_W     = 6;
  localparam int CB_WIDE   = 0;
  localparam int CB_RD     = 1;
  localparam int CB_BURST  = 2;
  localparam int CB_ECC    = 3;
  localparam int CB_FORCE  = 5;
endpackage

// File: rtl/nds_regs.sv
module nds_regs
  import nds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             fl_ready,
  input  logic             tc_hit,
  output logic [CFG_W-1:0] cfg,
  output logic [1:0]       ien,
  output logic [1:0]       stat,
  output logic             irq,
  output logic             start,
  output logic             ecc_clr,
  output logic             cnt_we
);
  logic             cfg_en, ien_en, iclr;
  logic             rdy_prev;
  logic [1:0]       stat_n;

  always_comb begin
    cfg_en  = wr && (addr == RA_CFG);
    ien_en  = wr && (addr == RA_IEN);
    iclr    = wr && (addr == RA_ICLR);
    cnt_we  = wr && (addr == RA_TCNT);
    start   = wr && (addr == RA_CTRL) && wdata[0];
    ecc_clr = wr && (addr == RA_CTRL) && wdata[1];
    stat_n[0] = (stat[0] && !(iclr && wdata[0])) || (fl_ready && !rdy_prev);
    stat_n[1] = (stat[1] && !(iclr && wdata[1])) || tc_hit;
    irq = |(stat & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      ien      <= '0;
      stat     <= '0;
      rdy_prev <= 1'b0;
    end else begin
      if (cfg_en) cfg <= wdata;
      if (ien_en) ien <= wdata[1:0];
      stat     <= stat_n;
      rdy_prev <= fl_ready;
    end
  end
endmodule

// File: rtl/nds_xfer.sv
module nds_xfer #(
  parameter int CNT_W     = 12,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             start,
  input  logic             burst_en,
  input  logic             fl_ready,
  input  logic             dma_ack,
  output logic [CNT_W-1:0] rem,
  output logic             active,
  output logic             dma_req,
  output logic             dma_burst,
  output logic             take,
  output logic             tc_hit
);
  localparam int BYTES = DATA_W / 8;
  localparam int BW    = $clog2(BURST_LEN);
  localparam logic [CNT_W-1:0] STEP        = CNT_W'(BYTES);
  localparam logic [CNT_W-1:0] BURST_BYTES = CNT_W'(BURST_LEN * BYTES);

  logic [BW-1:0]    beat, beat_n;
  logic [CNT_W-1:0] rem_n;
  logic             active_n;

  always_comb begin
    dma_req   = active && ((beat != '0) || fl_ready);
    dma_burst = active && ((beat != '0) || (burst_en && (rem >= BURST_BYTES)));
    take      = dma_req && dma_ack;
    tc_hit    = take && (rem <= STEP);
    rem_n     = rem;
    active_n  = active;
    beat_n    = beat;
    if (!active) begin
      if (cnt_we) rem_n = cnt_wdata;
      if (start && (rem != '0)) begin
        active_n = 1'b1;
        beat_n   = '0;
      end
    end else if (take) begin
      rem_n = tc_hit ? '0 : (rem - STEP);
      if (tc_hit) active_n = 1'b0;
      if (beat != '0)     beat_n = beat + BW'(1);
      else if (dma_burst) beat_n = BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem    <= '0;
      active <= 1'b0;
      beat   <= '0;
    end else begin
      rem    <= rem_n;
      active <= active_n;
      beat   <= beat_n;
    end
  end
endmodule

// File: rtl/nds_ecc.sv
module nds_ecc #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              take,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] acc_n;
  logic              acc_en;

  always_comb begin
    acc_en = clr || (en && take);
    acc_n  = (clr ? '0 : acc) ^ ((en && take) ? word : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (acc_en) acc <= acc_n;
  end
endmodule

// File: rtl/nand_dma_seq.sv
module nand_dma_seq
  import nds_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              dma_req,
  output logic              dma_burst,
  input  logic              dma_ack,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic [DATA_W-1:0] dma_rdata,
  input  logic              fl_ready,
  output logic              fl_ce_n,
  output logic              fl_wide,
  output logic              fl_dir_rd,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              fl_wstb,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              fl_rstb
);
  logic [1:0]        rst_sync;
  logic              rst_sn;
  logic [CFG_W-1:0]  cfg;
  logic [1:0]        ien, stat;
  logic              start, ecc_clr, cnt_we, take, tc_hit, active;
  logic [CNT_W-1:0]  rem;
  logic [DATA_W-1:0] ecc_word, ecc_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  nds_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata[CFG_W-1:0]), .fl_ready(fl_ready), .tc_hit(tc_hit),
    .cfg(cfg), .ien(ien), .stat(stat), .irq(irq),
    .start(start), .ecc_clr(ecc_clr), .cnt_we(cnt_we)
  );

  nds_xfer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) u_xfer (
    .clk(clk), .rst_n(rst_sn), .cnt_we(cnt_we), .cnt_wdata(reg_wdata[CNT_W-1:0]),
    .start(start), .burst_en(cfg[CB_BURST]), .fl_ready(fl_ready), .dma_ack(dma_ack),
    .rem(rem), .active(active), .dma_req(dma_req), .dma_burst(dma_burst),
    .take(take), .tc_hit(tc_hit)
  );

  assign ecc_word = cfg[CB_RD] ? fl_rdata : dma_wdata;

  nds_ecc #(.DATA_W(DATA_W)) u_ecc (
    .clk(clk), .rst_n(rst_sn), .clr(ecc_clr), .en(cfg[CB_ECC]),
    .take(take), .word(ecc_word), .acc(ecc_acc)
  );

  always_comb begin
    fl_ce_n   = !(cfg[CB_FORCE] || active);
    fl_wide   = cfg[CB_WIDE];
    fl_dir_rd = cfg[CB_RD];
    fl_wdata  = dma_wdata;
    dma_rdata = fl_rdata;
    fl_wstb   = take && !cfg[CB_RD];
    fl_rstb   = take && cfg[CB_RD];
    case (reg_addr)
      RA_CFG:  reg_rdata = DATA_W'(cfg);
      RA_IEN:  reg_rdata = DATA_W'(ien);
      RA_STAT: reg_rdata = DATA_W'(stat);
      RA_TCNT: reg_rdata = DATA_W'(rem);
      RA_ECC:  reg_rdata = ecc_acc;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nds_chk.sv
module nds_chk #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              fl_ce_n,
  input logic              active,
  input logic [CNT_W-1:0]  rem,
  input logic [1:0]        stat
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(DATA_W / 8);

  // R5
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && rem > STEP) |=> (rem == $past(rem) - STEP));
  // R6
  a_r6_tc_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && rem <= STEP) |=> (stat[1] && !active && !dma_req));
  // R4
  a_r4_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (active && reg_wr && reg_addr == 3'd1 && reg_wdata[0] && !(dma_req && dma_ack))
    |=> $stable(rem));
  // R7
  a_r7_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !(reg_wr && reg_addr == 3'd4 && reg_wdata[1])) |=> stat[1]);
  // R2
  a_r2_ce_active: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !fl_ce_n);
  // R11
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !dma_req);
endmodule

bind nand_dma_seq nds_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dma_req(dma_req), .dma_ack(dma_ack),
  .fl_ce_n(fl_ce_n), .active(active), .rem(rem), .stat(stat)
);

// File: tb/nand_dma_seq_tb.sv
module nand_dma_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, dma_req, dma_burst, dma_ack;
  logic [31:0] dma_wdata, dma_rdata, fl_wdata, fl_rdata;
  logic        fl_ready, fl_ce_n, fl_wide, fl_dir_rd, fl_wstb, fl_rstb;

  always #4 clk = ~clk;

  nand_dma_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .dma_req(dma_req), .dma_burst(dma_burst), .dma_ack(dma_ack),
    .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .fl_ready(fl_ready),
    .fl_ce_n(fl_ce_n), .fl_wide(fl_wide), .fl_dir_rd(fl_dir_rd),
    .fl_wdata(fl_wdata), .fl_wstb(fl_wstb), .fl_rdata(fl_rdata), .fl_rstb(fl_rstb)
  );

  int errors = 0, checks = 0, cycles = 0;
  int ack_mode = 0, rdy_mode = 0;
  bit ack_pulse = 0;
  logic [31:0] lfsr = 32'h1234_5678;
  int n_burst_words = 0, n_wstb = 0, n_rstb = 0;

  // reference model state
  logic [5:0]  m_cfg;
  logic [1:0]  m_ien;
  int          m_rem, m_beat;
  bit          m_active, m_tc, m_rdy, m_prev;
  logic [31:0] m_ecc;

  function automatic bit f_req();
    return m_active && (m_beat != 0 || fl_ready);
  endfunction
  function automatic bit f_burst();
    return m_active && (m_beat != 0 || (m_cfg[2] && m_rem >= 16));
  endfunction
  function automatic bit f_irq();
    return (m_tc && m_ien[1]) || (m_rdy && m_ien[0]);
  endfunction
  function automatic logic [31:0] f_rdata(input logic [2:0] a);
    case (a)
      3'd0: return {26'd0, m_cfg};
      3'd2: return {30'd0, m_ien};
      3'd3: return {30'd0, m_tc, m_rdy};
      3'd5: return 32'(m_rem);
      3'd6: return m_ecc;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_ien = '0; m_rem = 0; m_beat = 0; m_active = 0;
      m_tc = 0; m_rdy = 0; m_prev = 0; m_ecc = '0;
    end else begin
      bit take, hit, iclr;
      logic [31:0] word;
      int n_rem, n_beat; bit n_active;
      take = f_req() && dma_ack;
      word = m_cfg[1] ? fl_rdata : dma_wdata;
      iclr = reg_wr && reg_addr == 3'd4;
      hit = 0; n_rem = m_rem; n_beat = m_beat; n_active = m_active;
      if (!m_active) begin
        if (reg_wr && reg_addr == 3'd5) n_rem = int'(reg_wdata[11:0]);
        if (reg_wr && reg_addr == 3'd1 && reg_wdata[0] && m_rem != 0) begin
          n_active = 1; n_beat = 0;
        end
      end else if (take) begin
        n_rem = (m_rem < 4) ? 0 : m_rem - 4;
        if (n_rem == 0) begin n_active = 0; hit = 1; end
        if (m_beat != 0) n_beat = (m_beat + 1) % 4;
        else if (f_burst()) n_beat = 1;
      end
      m_ecc = ((reg_wr && reg_addr == 3'd1 && reg_wdata[1]) ? 32'd0 : m_ecc)
              ^ ((m_cfg[3] && take) ? word : 32'd0);
      m_tc  = (m_tc && !(iclr && reg_wdata[1])) || hit;
      m_rdy = (m_rdy && !(iclr && reg_wdata[0])) || (fl_ready && !m_prev);
      m_prev = fl_ready;
      if (reg_wr && reg_addr == 3'd0) m_cfg = reg_wdata[5:0];
      if (reg_wr && reg_addr == 3'd2) m_ien = reg_wdata[1:0];
      m_rem = n_rem; m_beat = n_beat; m_active = n_active;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // stimulus drivers for the DMA and flash sides
  always @(negedge clk) begin
    lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'd0);
    dma_ack   = (ack_mode == 1) || (ack_mode == 2 && lfsr[3]) || ack_pulse;
    ack_pulse = 0;
    fl_ready  = (rdy_mode == 1) || (rdy_mode == 2 && (lfsr[7] || lfsr[9]));
    fl_rdata  = lfsr ^ 32'hA5A5_0000;
    dma_wdata = ~lfsr;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit t;
      t = f_req() && dma_ack;
      chk("R11 dma_req", dma_req, f_req());
      chk("R10 dma_burst", dma_burst, f_burst());
      chk("R9 irq", irq, f_irq());
      chk("R2 fl_ce_n", fl_ce_n, !(m_cfg[5] || m_active));
      chk("R2 fl_wide", fl_wide, m_cfg[0]);
      chk("R2 fl_dir_rd", fl_dir_rd, m_cfg[1]);
      chk("R13 fl_wstb", fl_wstb, t && !m_cfg[1]);
      chk("R13 fl_rstb", fl_rstb, t && m_cfg[1]);
      chk("R13 dma_rdata", dma_rdata, fl_rdata);
      chk("R13 fl_wdata", fl_wdata, dma_wdata);
      chk("R3 reg_rdata", reg_rdata, f_rdata(reg_addr));
      if (dma_req && dma_ack && dma_burst) n_burst_words++;
      if (fl_wstb) n_wstb++;
      if (fl_rstb) n_rstb++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_wr = 0; reg_addr = a; #3 v = reg_rdata;
  endtask
  task automatic setm(input int am, input int rm);
    @(posedge clk); #1 ack_mode = am; rdy_mode = rm;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (!m_active) break;
    end
    repeat (2) @(posedge clk);
  endtask
  task automatic clr_cnt();
    @(posedge clk); #1 n_burst_words = 0; n_wstb = 0; n_rstb = 0;
  endtask

  initial begin
    logic [31:0] v, e_saved;
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    dma_ack = 0; fl_ready = 0; fl_rdata = 0; dma_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reg", v, 0); end
    chk("R1 dma_req", dma_req, 0); chk("R1 irq", irq, 0); chk("R1 fl_ce_n", fl_ce_n, 1);

    // R2 config storage and pins
    wr(3'd0, 32'h3F); rd(3'd0, v); chk("R2 cfg readback", v, 32'h3F);
    chk("R2 wide", fl_wide, 1); chk("R2 dir", fl_dir_rd, 1); chk("R2 force ce", fl_ce_n, 0);

    // small page, read direction, bursts and ECC on
    wr(3'd0, 32'h0E); wr(3'd2, 32'h2); wr(3'd5, 32'h210);
    rd(3'd5, v); chk("R3 count load", v, 32'h210);
    clr_cnt(); setm(1, 1); wr(3'd1, 32'h1);
    repeat (10) @(posedge clk);
    wr(3'd5, 32'h10); wr(3'd1, 32'h1);
    rd(3'd5, v); chk("R3 busy write ignored", v, 32'(m_rem));
    chk("R3 busy write not loaded", (v == 32'h10), 0);
    wait_idle();
    rd(3'd5, v); chk("R5 count drained", v, 0);
    rd(3'd3, v); chk("R6 tc set (ready flag also set)", v, 32'h3);
    chk("R9 irq on tc", irq, 1);
    chk("R10 all words in bursts", n_burst_words, 132);
    chk("R13 read strobes", n_rstb, 132);
    rd(3'd6, v); chk("R12 ecc fold", v, m_ecc); chk("R12 ecc nonzero", (v != 0), 1);
    e_saved = v;

    // R7 clear, R9 irq drop
    wr(3'd4, 32'h2); rd(3'd3, v); chk("R7 tc cleared", v, 32'h1); chk("R9 irq low", irq, 0);
    wr(3'd4, 32'h1); rd(3'd3, v); chk("R7 ready flag cleared", v, 0);

    // R4 start with zero count ignored
    wr(3'd1, 32'h1); repeat (3) @(posedge clk);
    @(negedge clk); #3 chk("R4 zero count start", dma_req, 0); chk("R4 ce idle", fl_ce_n, 1);

    // R8 rising edge of ready
    setm(0, 0); repeat (3) @(posedge clk); setm(0, 1); repeat (2) @(posedge clk);
    rd(3'd3, v); chk("R8 ready edge", v, 32'h1); wr(3'd4, 32'h1);

    // R7 collision: clear in the same cycle as terminal count
    wr(3'd0, 32'h0); wr(3'd5, 32'h4); wr(3'd1, 32'h1);
    @(posedge clk); #1 ack_pulse = 1;
    wr(3'd4, 32'h2);
    rd(3'd3, v); chk("R7 set wins over clear", v, 32'h2);
    rd(3'd5, v); chk("R5 last word", v, 0);
    rd(3'd6, v); chk("R12 ecc unchanged when off", v, e_saved);
    wr(3'd1, 32'h2); rd(3'd6, v); chk("R12 ecc clear", v, 0);

    // spare-only, write direction, single words, ragged ready and ack
    wr(3'd4, 32'h3); wr(3'd0, 32'h08); wr(3'd5, 32'h10);
    clr_cnt(); setm(2, 2); wr(3'd1, 32'h1); wait_idle();
    chk("R13 write strobes", n_wstb, 4); chk("R10 no bursts when off", n_burst_words, 0);
    rd(3'd6, v); chk("R12 ecc write dir", v, m_ecc);

    // R11 request held off by low ready
    setm(0, 0); wr(3'd5, 32'h8); wr(3'd1, 32'h1); repeat (3) @(posedge clk);
    @(negedge clk); #3 chk("R11 held off", dma_req, 0);
    setm(1, 1); wait_idle();

    // large page, read direction, bursts, ready toggling
    wr(3'd4, 32'h3); wr(3'd0, 32'h0E); wr(3'd1, 32'h2); wr(3'd5, 32'h840);
    clr_cnt(); setm(2, 2); wr(3'd1, 32'h1); wait_idle();
    chk("R10 large page bursts", n_burst_words, 528); chk("R13 large page reads", n_rstb, 528);
    rd(3'd3, v); chk("R6 tc large page", v[1], 1);
    rd(3'd6, v); chk("R12 ecc large page", v, m_ecc);

    // ragged count: one burst then a short word
    wr(3'd4, 32'h3); wr(3'd5, 32'd18); clr_cnt(); setm(1, 1); wr(3'd1, 32'h1); wait_idle();
    chk("R10 burst then single", n_burst_words, 4); chk("R5 ragged words", n_rstb, 5);
    rd(3'd5, v); chk("R5 ragged end", v, 0);

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule